// File: doc/BRIEF.md
# Split-Array Translation Lookaside Lookup

The block looks up a 48-bit virtual address in a translation cache made of two parts. The first part is set-associative, with a number of ways times a number of sets, and all of its entries use one page size that the surrounding logic supplies on the `glb_ps` input. The second part is a small fully associative array, and each of its entries carries its own page size. Every entry describes a pair of adjacent pages, even and odd. It stores the virtual page-pair number as VA[47:13] along with an address-space tag, a global flag, a valid flag and two half-entry payloads.

A request carries an address and the current address-space tag and uses a valid/ready handshake. The response comes exactly one cycle after the request is accepted. It gives a hit flag, a flat entry index, the selected half-entry and the page size that applied. A write port fills any entry by its flat index, and a request cannot be accepted in a cycle that writes. Permission checks and page-table walks on a miss belong to other blocks.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is invalid: `rsp_valid` is low, `req_ready` is high and every lookup misses.
- R2: `req_ready` is low in every cycle where `wr_en` is high. Each accepted request produces exactly one cycle of `rsp_valid`, in the cycle right after acceptance, and `rsp_valid` is low otherwise.
- R3: An entry matches only if its valid flag is set and, in addition, either its global flag is set or its stored tag equals `req_asid`. Clearing the valid flag of a matching entry makes the next candidate, or a miss, visible.
- R4: In the set-associative part, the set of a lookup is bits [SET_W-1:0] of VA >> (glb_ps+1). Flat index w*SETS+s names way w, set s, and a hit reports that index and `rsp_ps` = `glb_ps`.
- R5: The address matches an entry when VA >> (ps+1) equals the stored page-pair number shifted right by ps−12. Stored page-pair bits below that position, and address bits below ps+1, have no effect (ps ≥ 12).
- R6: A fully associative entry k has flat index WAYS*SETS+k. Its compare uses its own page size, which `rsp_ps` reports on a hit.
- R7: A hit in the set-associative part takes precedence over any hit in the fully associative part.
- R8: When several ways hit, the lowest way wins. When several fully associative entries hit, the lowest index wins.
- R9: Address bit ps picks the half-entry: 1 returns the odd (`wr_hi`) payload and 0 returns the even (`wr_lo`) payload.
- R10: On a miss, `rsp_hit`, `rsp_idx` and `rsp_pte` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_ps | input | 6 | Page size (log2) of the set-associative part |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted |
| req_va | input | 48 | Virtual address to look up |
| req_asid | input | ASID_W | Current address-space tag |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Flat entry index of the write |
| wr_e | input | 1 | Valid flag written |
| wr_g | input | 1 | Global flag written |
| wr_asid | input | ASID_W | Address-space tag written |
| wr_vppn | input | 35 | Page-pair number (VA[47:13]) written |
| wr_ps | input | 6 | Page size written (fully associative entries only) |
| wr_lo | input | DATA_W | Even-page payload |
| wr_hi | input | DATA_W | Odd-page payload |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | IDX_W | Flat index of the hit entry |
| rsp_pte | output | DATA_W | Selected half-entry payload |
| rsp_ps | output | 6 | Page size that applied to the hit |

## Verification
The bench builds the block with 2 ways, 4 sets, 4 fully associative entries, 4-bit tags and 16-bit payloads, so that only 12 entries exist. With that size every set, way and fully associative slot can be filled and then probed by sweeps over tag, set, odd/even bit and address-space tag. This is done at two global page sizes, and the bench works out the expected results arithmetically. The small size also brings duplicate ways in one set, overlapping fully associative entries of different page sizes, and entries shadowed between the two parts into reach with only a handful of writes.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
  localparam int VA_W    = 48;
  localparam int VPN_LSB = 13;
  localparam int VPN_W   = VA_W - VPN_LSB;
  localparam int PS_W    = 6;
  localparam int PS_MIN  = 12;

  // Page-pair compare: page-pair number bits below (ps+1-VPN_LSB) are masked out.
  function automatic logic vpn_hit(input logic [VA_W-1:0]  va,
                                   input logic [VPN_W-1:0] vppn,
                                   input logic [PS_W-1:0]  ps);
    logic [VPN_W-1:0] keep;
    keep = {VPN_W{1'b1}} << (ps - PS_W'(PS_MIN));
    return ((va[VA_W-1:VPN_LSB] ^ vppn) & keep) == '0;
  endfunction

  // Address bit ps selects the odd half of the pair.
  function automatic logic odd_half(input logic [VA_W-1:0] va,
                                    input logic [PS_W-1:0] ps);
    logic [VA_W-1:0] sh;
    sh = va >> ps;
    return sh[0];
  endfunction
endpackage

// File: rtl/tlbl_set_array.sv
module tlbl_set_array
  import tlbl_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int SETS   = 256,
  parameter int ASID_W = 10,
  parameter int DATA_W = 64,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              wr_e,
  input  logic              wr_g,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vppn,
  input  logic [DATA_W-1:0] wr_lo,
  input  logic [DATA_W-1:0] wr_hi,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [VA_W-1:0]   cmp_va,
  input  logic [ASID_W-1:0] cmp_asid,
  input  logic [PS_W-1:0]   cmp_ps,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic [DATA_W-1:0] pte
);
  localparam int ROW_W  = 1 + ASID_W + VPN_W + 2 * DATA_W;
  localparam int VPN_LO = 2 * DATA_W;
  localparam int ASID_LO = VPN_LO + VPN_W;

  logic [ROW_W-1:0]  wr_row;
  logic [WAYS-1:0]   way_hit;
  logic [DATA_W-1:0] way_pte [WAYS];

  assign wr_row = {wr_g, wr_asid, wr_vppn, wr_hi, wr_lo};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ROW_W-1:0] mem [SETS];
    logic [ROW_W-1:0] row_q;
    logic [SETS-1:0]  e_q;
    logic             e_rd;
    logic             we;

    assign we = wr_en && (wr_way == WAY_W'(w));

    // payload RAM: no reset, synchronous read
    always_ff @(posedge clk) begin
      if (we)    mem[wr_set] <= wr_row;
      if (rd_en) row_q <= mem[rd_set];
    end

    // valid flags live in flops so reset clears them in one cycle
    always_ff @(posedge clk) begin
      if (rst) begin
        e_q  <= '0;
        e_rd <= 1'b0;
      end else begin
        if (we)    e_q[wr_set] <= wr_e;
        if (rd_en) e_rd <= e_q[rd_set];
      end
    end

    assign way_hit[w] = e_rd
                        && (row_q[ROW_W-1] || (row_q[ASID_LO +: ASID_W] == cmp_asid))
                        && vpn_hit(cmp_va, row_q[VPN_LO +: VPN_W], cmp_ps);
    assign way_pte[w] = odd_half(cmp_va, cmp_ps) ? row_q[DATA_W +: DATA_W]
                                                 : row_q[DATA_W-1:0];
  end

  // lowest way wins
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    pte     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
        pte     = way_pte[w];
      end
    end
  end

  AST_SA_HIT_HAS_WAY: assert property (@(posedge clk) disable iff (rst)
    hit |-> way_hit[hit_way]);  // R8
endmodule

// File: rtl/tlbl_fa_array.sv
module tlbl_fa_array
  import tlbl_pkg::*;
#(
  parameter int N      = 64,
  parameter int ASID_W = 10,
  parameter int DATA_W = 64,
  localparam int IX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IX_W-1:0]   wr_slot,
  input  logic              wr_e,
  input  logic              wr_g,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vppn,
  input  logic [PS_W-1:0]   wr_ps,
  input  logic [DATA_W-1:0] wr_lo,
  input  logic [DATA_W-1:0] wr_hi,
  input  logic              lk_en,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [IX_W-1:0]   slot,
  output logic [DATA_W-1:0] pte,
  output logic [PS_W-1:0]   ps
);
  logic [N-1:0]      e_q;
  logic [N-1:0]      g_q;
  logic [ASID_W-1:0] asid_q [N];
  logic [VPN_W-1:0]  vppn_q [N];
  logic [PS_W-1:0]   ps_q   [N];
  logic [DATA_W-1:0] lo_q   [N];
  logic [DATA_W-1:0] hi_q   [N];
  logic [N-1:0]      ent_hit;
  logic              any;
  logic [IX_W-1:0]   sel;

  always_ff @(posedge clk) begin
    if (rst) e_q <= '0;
    else if (wr_en) e_q[wr_slot] <= wr_e;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      g_q[wr_slot]    <= wr_g;
      asid_q[wr_slot] <= wr_asid;
      vppn_q[wr_slot] <= wr_vppn;
      ps_q[wr_slot]   <= wr_ps;
      lo_q[wr_slot]   <= wr_lo;
      hi_q[wr_slot]   <= wr_hi;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_ent
    assign ent_hit[k] = e_q[k] && (g_q[k] || (asid_q[k] == lk_asid))
                        && vpn_hit(lk_va, vppn_q[k], ps_q[k]);
  end

  // lowest index wins
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (ent_hit[k]) begin
        any = 1'b1;
        sel = IX_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit  <= 1'b0;
      slot <= '0;
      pte  <= '0;
      ps   <= '0;
    end else if (lk_en) begin
      hit  <= any;
      slot <= any ? sel : '0;
      pte  <= any ? (odd_half(lk_va, ps_q[sel]) ? hi_q[sel] : lo_q[sel]) : '0;
      ps   <= any ? ps_q[sel] : '0;
    end
  end

  AST_FA_EMPTY_MISSES: assert property (@(posedge clk) disable iff (rst)
    (lk_en && (e_q == '0)) |=> !hit);  // R3
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlbl_pkg::*;
#(
  parameter int WAYS   = 8,
  parameter int SETS   = 256,
  parameter int FA_N   = 64,
  parameter int ASID_W = 10,
  parameter int DATA_W = 64,
  localparam int SA_N  = WAYS * SETS,
  localparam int IDX_W = $clog2(SA_N + FA_N),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int FA_W  = (FA_N > 1) ? $clog2(FA_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PS_W-1:0]   glb_ps,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_e,
  input  logic              wr_g,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vppn,
  input  logic [PS_W-1:0]   wr_ps,
  input  logic [DATA_W-1:0] wr_lo,
  input  logic [DATA_W-1:0] wr_hi,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [DATA_W-1:0] rsp_pte,
  output logic [PS_W-1:0]   rsp_ps
);
  logic              accept;
  logic              wr_fa;
  logic [SET_W-1:0]  req_set;
  logic [VA_W-1:0]   req_shift;
  logic              s_vld;
  logic [VA_W-1:0]   s_va;
  logic [ASID_W-1:0] s_asid;
  logic [PS_W-1:0]   s_ps;
  logic [SET_W-1:0]  s_set;
  logic              sa_hit;
  logic [WAY_W-1:0]  sa_way;
  logic [DATA_W-1:0] sa_pte;
  logic              fa_hit;
  logic [FA_W-1:0]   fa_slot;
  logic [DATA_W-1:0] fa_pte;
  logic [PS_W-1:0]   fa_ps;

  assign req_ready = !wr_en;
  assign accept    = req_valid && req_ready;
  assign req_shift = req_va >> ({1'b0, glb_ps} + 7'd1);
  assign req_set   = req_shift[SET_W-1:0];
  assign wr_fa     = (wr_idx >= IDX_W'(SA_N));

  always_ff @(posedge clk) begin
    if (rst) s_vld <= 1'b0;
    else     s_vld <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s_va   <= req_va;
      s_asid <= req_asid;
      s_ps   <= glb_ps;
      s_set  <= req_set;
    end
  end

  tlbl_set_array #(.WAYS(WAYS), .SETS(SETS), .ASID_W(ASID_W), .DATA_W(DATA_W)) i_sa (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && !wr_fa),
    .wr_way  (wr_idx[SET_W +: WAY_W]),
    .wr_set  (wr_idx[SET_W-1:0]),
    .wr_e    (wr_e),
    .wr_g    (wr_g),
    .wr_asid (wr_asid),
    .wr_vppn (wr_vppn),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .rd_en   (accept),
    .rd_set  (req_set),
    .cmp_va  (s_va),
    .cmp_asid(s_asid),
    .cmp_ps  (s_ps),
    .hit     (sa_hit),
    .hit_way (sa_way),
    .pte     (sa_pte)
  );

  tlbl_fa_array #(.N(FA_N), .ASID_W(ASID_W), .DATA_W(DATA_W)) i_fa (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en && wr_fa),
    .wr_slot(FA_W'(wr_idx - IDX_W'(SA_N))),
    .wr_e   (wr_e),
    .wr_g   (wr_g),
    .wr_asid(wr_asid),
    .wr_vppn(wr_vppn),
    .wr_ps  (wr_ps),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .lk_en  (accept),
    .lk_va  (req_va),
    .lk_asid(req_asid),
    .hit    (fa_hit),
    .slot   (fa_slot),
    .pte    (fa_pte),
    .ps     (fa_ps)
  );

  // set-associative hit takes precedence over the fully associative one
  always_comb begin
    rsp_valid = s_vld;
    rsp_hit   = 1'b0;
    rsp_idx   = '0;
    rsp_pte   = '0;
    rsp_ps    = '0;
    if (s_vld && sa_hit) begin
      rsp_hit = 1'b1;
      rsp_idx = IDX_W'({sa_way, s_set});
      rsp_pte = sa_pte;
      rsp_ps  = s_ps;
    end else if (s_vld && fa_hit) begin
      rsp_hit = 1'b1;
      rsp_idx = IDX_W'(SA_N) + IDX_W'(fa_slot);
      rsp_pte = fa_pte;
      rsp_ps  = fa_ps;
    end
  end

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);  // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);  // R2
  AST_PS_FLOOR: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (glb_ps >= PS_W'(PS_MIN)));  // R5
  AST_SA_PS_USED: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && (rsp_idx < IDX_W'(SA_N))) |-> (rsp_ps == $past(glb_ps)));  // R4
  AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);  // R2
endmodule

// File: tb/test_tlb_lookup.sv
module test_tlb_lookup;
  import tlbl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WAYS   = 2;
  localparam int SETS   = 4;
  localparam int FA_N   = 4;
  localparam int ASID_W = 4;
  localparam int DATA_W = 16;
  localparam int SA_N   = WAYS * SETS;
  localparam int TOT    = SA_N + FA_N;
  localparam int IDX_W  = $clog2(TOT);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [PS_W-1:0]   glb_ps = 6'd12;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [VA_W-1:0]   req_va = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic              wr_e = 1'b0;
  logic              wr_g = 1'b0;
  logic [ASID_W-1:0] wr_asid = '0;
  logic [VPN_W-1:0]  wr_vppn = '0;
  logic [PS_W-1:0]   wr_ps = '0;
  logic [DATA_W-1:0] wr_lo = '0;
  logic [DATA_W-1:0] wr_hi = '0;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [IDX_W-1:0]  rsp_idx;
  logic [DATA_W-1:0] rsp_pte;
  logic [PS_W-1:0]   rsp_ps;

  int checks = 0;
  int errors = 0;

  // bench-side copy of the written entries
  bit          m_e    [TOT];
  bit          m_g    [TOT];
  int          m_asid [TOT];
  logic [63:0] m_vppn [TOT];
  int          m_ps   [TOT];
  logic [63:0] m_lo   [TOT];
  logic [63:0] m_hi   [TOT];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_lookup #(.WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .ASID_W(ASID_W), .DATA_W(DATA_W))
  i_tlb_lookup (
    .clk(clk), .rst(rst), .glb_ps(glb_ps),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_asid(req_asid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_e(wr_e), .wr_g(wr_g), .wr_asid(wr_asid),
    .wr_vppn(wr_vppn), .wr_ps(wr_ps), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_pte(rsp_pte), .rsp_ps(rsp_ps)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  // expected lookup result worked out from the requirements
  task automatic expect_of(input logic [63:0] va, input int asid, input int gps,
                           output bit hit, output int idx, output logic [63:0] pte,
                           output int ps);
    hit = 0; idx = 0; pte = 0; ps = 0;
    for (int w = 0; w < WAYS; w++) begin
      int s = int'((va >> (gps + 1)) % SETS);
      int i = w * SETS + s;
      if (!hit && m_e[i] && (m_g[i] || m_asid[i] == asid)
          && ((va >> (gps + 1)) == (m_vppn[i] >> (gps + 1 - 13)))) begin
        hit = 1; idx = i; ps = gps;
        pte = ((va >> gps) & 64'd1) != 0 ? m_hi[i] : m_lo[i];
      end
    end
    for (int k = 0; k < FA_N; k++) begin
      int i = SA_N + k;
      int p = m_ps[i];
      if (!hit && m_e[i] && (m_g[i] || m_asid[i] == asid)
          && ((va >> (p + 1)) == (m_vppn[i] >> (p + 1 - 13)))) begin
        hit = 1; idx = i; ps = p;
        pte = ((va >> p) & 64'd1) != 0 ? m_hi[i] : m_lo[i];
      end
    end
  endtask

  task automatic wr(input int idx, input bit e, input bit g, input int asid,
                    input logic [63:0] vppn, input int ps);
    m_e[idx] = e; m_g[idx] = g; m_asid[idx] = asid; m_vppn[idx] = vppn;
    m_ps[idx] = ps; m_lo[idx] = 64'hA000 | 64'(idx); m_hi[idx] = 64'hB000 | 64'(idx);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_e = e; wr_g = g; wr_asid = ASID_W'(asid);
    wr_vppn = VPN_W'(vppn); wr_ps = PS_W'(ps);
    wr_lo = DATA_W'(m_lo[idx]); wr_hi = DATA_W'(m_hi[idx]);
    req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R2", "ready during write", 64'(req_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b0;
  endtask

  // one lookup; returns the actual response for extra targeted checks
  task automatic lk(input logic [63:0] va, input int asid, input string req,
                    output bit a_hit, output int a_idx, output logic [63:0] a_pte,
                    output int a_ps);
    bit e_hit; int e_idx; logic [63:0] e_pte; int e_ps;
    string tag;
    expect_of(va, asid, int'(glb_ps), e_hit, e_idx, e_pte, e_ps);
    req_valid = 1'b1; req_va = VA_W'(va); req_asid = ASID_W'(asid);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    a_hit = rsp_hit; a_idx = int'(rsp_idx); a_pte = 64'(rsp_pte); a_ps = int'(rsp_ps);
    tag = (req != "") ? req : (!e_hit ? "R10" : (e_idx < SA_N ? "R4" : "R6"));
    chk(rsp_valid == 1'b1 && a_hit == e_hit && a_idx == e_idx && a_pte == e_pte
        && (!e_hit || a_ps == e_ps), tag, $sformatf("lookup va=%0h asid=%0d", va, asid),
        {a_hit, 7'(a_idx), 8'(a_ps), 48'(a_pte)}, {e_hit, 7'(e_idx), 8'(e_ps), 48'(e_pte)});
  endtask

  task automatic lk0(input logic [63:0] va, input int asid, input string req);
    bit h; int i; logic [63:0] p; int s;
    lk(va, asid, req, h, i, p, s);
  endtask

  // fill the set-associative part for page size gps
  task automatic fill_sa(input int gps);
    for (int w = 0; w < WAYS; w++) begin
      for (int s = 0; s < SETS; s++) begin
        int tg = (w == 1 && s == 3) ? 1 : w + 1;     // way 1 set 3 duplicates way 0
        logic [63:0] va = (64'(tg) << (gps + 3)) | (64'(s) << (gps + 1));
        logic [63:0] vp = (va >> 13) | ((gps > 12) ? 64'd1 : 64'd0);  // junk below the compare
        wr(w * SETS + s, !(w == 1 && s == 1), s == 0, s % 3, vp, 0);
      end
    end
  endtask

  function automatic logic [63:0] fa_base(input int b);
    case (b)
      0: return 64'h0000_1234_0000;
      1: return 64'h0000_0002_8000;
      2: return 64'h0000_FFFF_F000_0000 & 64'hFFFF_FFFF_FFFF;
      default: return 64'h0000_0003_8000;
    endcase
  endfunction

  function automatic logic [63:0] fa_off(input int o);
    case (o)
      0: return 64'h0;
      1: return 64'h1800;
      2: return 64'h1_0000;
      3: return 64'h1F_F000;
      default: return 64'h20_0000;
    endcase
  endfunction

  initial begin
    bit h; int i; logic [63:0] p; int s;
    for (int k = 0; k < TOT; k++) begin
      m_e[k] = 0; m_g[k] = 0; m_asid[k] = 0; m_vppn[k] = 0; m_ps[k] = 12;
      m_lo[k] = 0; m_hi[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    lk0(64'h0, 0, "R1");
    lk0(64'h0000_1234_5678, 3, "R1");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "no response without request", 64'(rsp_valid), 64'd0);

    // sweep at global page size 12
    glb_ps = 6'd12;
    fill_sa(12);
    for (int tg = 0; tg < 4; tg++)
      for (int st = 0; st < SETS; st++)
        for (int od = 0; od < 2; od++)
          for (int as = 0; as < 3; as++)
            lk0((64'(tg) << 15) | (64'(st) << 13) | (64'(od) << 12) | 64'(as * 291 + 7), as, "");

    // sweep at global page size 14, with address bits below ps+1 varied (R5)
    glb_ps = 6'd14;
    fill_sa(14);
    for (int tg = 0; tg < 4; tg++)
      for (int st = 0; st < SETS; st++)
        for (int od = 0; od < 2; od++)
          for (int as = 0; as < 3; as++)
            lk0((64'(tg) << 17) | (64'(st) << 15) | (64'(od) << 14)
                | (64'(as * 5461 + tg * 4097) & 64'h3FFF), as, "");

    // R5: bit 13 set, below ps+1 = 15, still hits way 0 set 1
    lk(64'h2A000, 1, "R5", h, i, p, s);
    chk(h && i == 1 && p == 64'hA001, "R5", "low address bits ignored", 64'(i), 64'd1);

    // fully associative entries
    wr(SA_N + 0, 1, 1, 0, 64'h0000_1234_0000 >> 13, 16);
    wr(SA_N + 1, 1, 1, 0, 64'h0000_1234_0000 >> 13, 12);
    wr(SA_N + 2, 1, 1, 0, 64'h2_8000 >> 13, 14);
    wr(SA_N + 3, 1, 0, 5, 64'hFFFF_F000_0000 >> 13, 20);

    // R6: own page size of slot 0 covers an address slot 1 does not
    lk(64'h0000_1234_3000, 0, "R6", h, i, p, s);
    chk(h && i == SA_N && s == 16 && p == 64'hA008, "R6", "fa own page size",
        {32'(i), 32'(s)}, {32'(SA_N), 32'd16});
    // R8: slots 0 and 1 both match, slot 0 wins
    lk(64'h0000_1234_0100, 7, "R8", h, i, p, s);
    chk(h && i == SA_N, "R8", "fa lowest index", 64'(i), 64'(SA_N));
    // R9: bit 16 selects odd half of slot 0
    lk(64'h0000_1235_0000, 0, "R9", h, i, p, s);
    chk(h && p == 64'hB008, "R9", "odd half", p, 64'hB008);
    lk(64'h0000_1234_1000, 0, "R9", h, i, p, s);
    chk(h && p == 64'hA008, "R9", "even half", p, 64'hA008);
    // R7: set-associative entry shadows fa slot 2 when the tag matches
    lk(64'h2_8000, 1, "R7", h, i, p, s);
    chk(h && i == 1 && s == 14, "R7", "set part first", 64'(i), 64'd1);
    lk(64'h2_8000, 0, "R3", h, i, p, s);
    chk(h && i == SA_N + 2, "R3", "tag mismatch falls through", 64'(i), 64'(SA_N + 2));
    // R3: slot 3 needs tag 5
    lk(64'hFFFF_F001_2345, 4, "R3", h, i, p, s);
    chk(!h, "R3", "non-global tag mismatch", 64'(h), 64'd0);
    lk(64'hFFFF_F001_2345, 5, "R6", h, i, p, s);
    chk(h && i == SA_N + 3 && s == 20, "R6", "large fa page", 64'(i), 64'(SA_N + 3));
    // R8: set 3 holds the same pair in both ways
    lk(64'h3_8000, 0, "R8", h, i, p, s);
    chk(h && i == 3 && p == 64'hA003, "R8", "lowest way", 64'(i), 64'd3);
    // R3: clearing the valid flag of way 0 exposes way 1
    wr(3, 0, 0, 0, 64'h3_8000 >> 13, 0);
    lk(64'h3_8000, 0, "R3", h, i, p, s);
    chk(h && i == 7 && p == 64'hA007, "R3", "cleared entry skipped", 64'(i), 64'd7);
    // R10: a plain miss
    lk(64'h7FFF_0000_0000, 2, "R10", h, i, p, s);
    chk(!h && i == 0 && p == 0, "R10", "miss zeroes", p, 64'd0);

    // mixed sweep over both parts
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 5; o++)
        for (int a = 0; a < 3; a++)
          lk0(fa_base(b) + fa_off(o), (a == 2) ? 5 : a, "");

    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "single-cycle response", 64'(rsp_valid), 64'd0);
    finish_run();
  end
endmodule